// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block owns the program counter of a 32-bit processor and picks its next value on every clock. There are three candidates. The first is the sequential address, which is the current PC plus one 4-byte word. The second is a PC-relative branch target. The third is an absolute jump target spliced from the instruction word. The block decodes the six-bit opcode at the top of the instruction. For the two conditional branches it compares the two register operands it receives. It then loads the chosen address into the PC register, unless the stall input holds the PC where it is.

Branch offsets are signed word counts measured from the address that follows the branch. A jump keeps the top four bits of that following address and fills in the remaining bits from the instruction's 26-bit word index, with two zero bits appended at the bottom. A registered taken flag marks each update that left the sequential path. The register file, the instruction memory and the hazard logic sit outside this block.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, `pc_q` becomes 0 and `taken_q` becomes 0; both hold those values in the first cycle after `rst` falls.
- R2: When `stall` is high at a clock edge, `pc_q` keeps its value and `taken_q` becomes 0, whatever the instruction and operands are.
- R3: With `stall` low, an instruction whose opcode `instr[31:26]` is none of 4, 5 or 2 loads `pc_q + 4` into `pc_q` and clears `taken_q`.
- R4: Opcode 4 (branch if equal) with `src_a == src_b` loads `pc_q + 4 + (sign-extended instr[15:0] << 2)` and sets `taken_q`.
- R5: Opcode 5 (branch if not equal) with `src_a != src_b` loads the same branch target as R4 and sets `taken_q`.
- R6: A branch whose condition fails (opcode 4 with unequal operands, or opcode 5 with equal operands) loads `pc_q + 4` and clears `taken_q`.
- R7: The 16-bit branch offset is two's complement, so an offset with bit 15 set moves the PC backward. The offset 0x8000 reaches 2^15 words below `pc_q + 4`.
- R8: Opcode 2 (jump) loads `{(pc_q+4)[31:28], instr[25:0], 2'b00}` and sets `taken_q`, whatever the operand values are. The top four bits come from the incremented PC, not from `pc_q`.
- R9: `taken_q` is registered. It is high for exactly the cycle that follows an update that loaded a branch or jump target, and low after any sequential update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Holds the PC when high |
| instr | input | 32 | Instruction at the current PC |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| pc_q | output | 32 | Program counter register |
| taken_q | output | 1 | Previous update left the sequential path |

## Verification
The assertions take for granted that `rst` is held high at the first clock edge, so that every `$past` they read refers to a defined PC. They also assume the reset address is word-aligned. The stimulus raises reset before the first edge and holds it for several cycles. It changes `instr`, `src_a`, `src_b` and `stall` only on falling edges, so every input is stable around the rising edge that consumes it. Jump and branch targets are chosen to cross a 256 MiB region boundary and to use the most negative branch offset.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [1:0] {
    FLOW_SEQ = 2'd0,
    FLOW_BEQ = 2'd1,
    FLOW_BNE = 2'd2,
    FLOW_JMP = 2'd3
  } flow_e;

  localparam int OPC_BITS = 6;
  localparam logic [OPC_BITS-1:0] OPC_BEQ = 6'd4;
  localparam logic [OPC_BITS-1:0] OPC_BNE = 6'd5;
  localparam logic [OPC_BITS-1:0] OPC_JMP = 6'd2;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
#(
  parameter int OPC_W = OPC_BITS
) (
  input  logic [OPC_W-1:0] opcode,
  output flow_e            flow
);
  always_comb begin
    unique case (opcode)
      OPC_BEQ: flow = FLOW_BEQ;
      OPC_BNE: flow = FLOW_BNE;
      OPC_JMP: flow = FLOW_JMP;
      default: flow = FLOW_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  flow_e           flow,
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  output logic            redirect
);
  logic same;

  assign same = (opnd_a == opnd_b);

  always_comb begin
    unique case (flow)
      FLOW_BEQ: redirect = same;
      FLOW_BNE: redirect = !same;
      FLOW_JMP: redirect = 1'b1;
      default:  redirect = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target #(
  parameter int XLEN   = 32,
  parameter int OFF_W  = 16,
  parameter int JIDX_W = 26
) (
  input  logic [XLEN-1:0]   pc,
  input  logic [OFF_W-1:0]  br_off,
  input  logic [JIDX_W-1:0] jmp_idx,
  output logic [XLEN-1:0]   seq_pc,
  output logic [XLEN-1:0]   br_pc,
  output logic [XLEN-1:0]   jmp_pc
);
  localparam int BYTE_SH = 2;
  localparam int EXT_W   = XLEN - OFF_W - BYTE_SH;
  localparam int HI_W    = XLEN - JIDX_W - BYTE_SH;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] off_bytes;

  assign seq_pc    = pc + STEP;
  assign off_bytes = {{EXT_W{br_off[OFF_W-1]}}, br_off, {BYTE_SH{1'b0}}};
  assign br_pc     = seq_pc + off_bytes;
  assign jmp_pc    = {seq_pc[XLEN-1 -: HI_W], jmp_idx, {BYTE_SH{1'b0}}};
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import npc_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              OPC_W    = OPC_BITS,
  parameter int              OFF_W    = 16,
  parameter int              JIDX_W   = 26,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stall,
  input  logic [XLEN-1:0] instr,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic [XLEN-1:0] pc_q,
  output logic            taken_q
);
  localparam int HI_W = XLEN - JIDX_W - 2;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  flow_e           flow;
  logic            redirect;
  logic [XLEN-1:0] seq_pc, br_pc, jmp_pc, next_pc;

  npc_decode #(.OPC_W(OPC_W)) u_dec (
    .opcode (instr[XLEN-1 -: OPC_W]),
    .flow   (flow)
  );

  npc_cond #(.XLEN(XLEN)) u_cond (
    .flow     (flow),
    .opnd_a   (src_a),
    .opnd_b   (src_b),
    .redirect (redirect)
  );

  npc_target #(.XLEN(XLEN), .OFF_W(OFF_W), .JIDX_W(JIDX_W)) u_tgt (
    .pc      (pc_q),
    .br_off  (instr[OFF_W-1:0]),
    .jmp_idx (instr[JIDX_W-1:0]),
    .seq_pc  (seq_pc),
    .br_pc   (br_pc),
    .jmp_pc  (jmp_pc)
  );

  always_comb begin
    next_pc = seq_pc;
    if (redirect) next_pc = (flow == FLOW_JMP) ? jmp_pc : br_pc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= RESET_PC;
      taken_q <= 1'b0;
    end else if (stall) begin
      taken_q <= 1'b0;
    end else begin
      pc_q    <= next_pc;
      taken_q <= redirect;
    end
  end

  // R1: reset state seen right after reset releases
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc_q == RESET_PC) && !taken_q);

  // R2: stall freezes the PC and drops the flag
  a_r2_stall_hold: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(pc_q) && !taken_q);

  // R3: plain instructions step one word
  a_r3_seq_step: assert property (@(posedge clk) disable iff (rst)
    (!stall && flow == FLOW_SEQ) |=> (pc_q == $past(pc_q) + STEP) && !taken_q);

  // R4: equal operands on branch-if-equal take the branch
  a_r4_beq_taken: assert property (@(posedge clk) disable iff (rst)
    (!stall && flow == FLOW_BEQ && src_a == src_b) |=> taken_q && (pc_q == $past(br_pc)));

  // R5: differing operands on branch-if-not-equal take the branch
  a_r5_bne_taken: assert property (@(posedge clk) disable iff (rst)
    (!stall && flow == FLOW_BNE && src_a != src_b) |=> taken_q && (pc_q == $past(br_pc)));

  // R6: failed branch falls through
  a_r6_fallthrough: assert property (@(posedge clk) disable iff (rst)
    (!stall && ((flow == FLOW_BEQ && src_a != src_b) || (flow == FLOW_BNE && src_a == src_b)))
    |=> !taken_q && (pc_q == $past(pc_q) + STEP));

  // R8: jump keeps the upper bits of the incremented PC and stays aligned
  a_r8_jump_splice: assert property (@(posedge clk) disable iff (rst)
    (!stall && flow == FLOW_JMP) |=> taken_q
      && (pc_q[XLEN-1 -: HI_W] == $past(seq_pc[XLEN-1 -: HI_W])) && (pc_q[1:0] == 2'b00));
endmodule

// File: tb/pc_sequencer_test.sv
`timescale 1ns/1ps
module pc_sequencer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [31:0] pc_q;
  logic        taken_q;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  pc_sequencer uut (
    .clk(clk), .rst(rst), .stall(stall), .instr(instr),
    .src_a(src_a), .src_b(src_b), .pc_q(pc_q), .taken_q(taken_q)
  );

  function automatic logic [31:0] br(input logic [5:0] op, input logic [15:0] off);
    return {op, 5'd9, 5'd10, off};
  endfunction

  function automatic logic [31:0] jmp(input logic [25:0] idx);
    return {6'd2, idx};
  endfunction

  task automatic check(input string tag, input logic [31:0] exp_pc, input logic exp_tk);
    checks++;
    if (pc_q !== exp_pc || taken_q !== exp_tk) begin
      errors++;
      $display("FAIL %s: pc=%h taken=%b expected pc=%h taken=%b", tag, pc_q, taken_q, exp_pc, exp_tk);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, sample at the next falling edge
  task automatic step(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b,
                      input logic st, input string tag, input logic [31:0] exp_pc, input logic exp_tk);
    instr = i; src_a = a; src_b = b; stall = st;
    @(negedge clk);
    check(tag, exp_pc, exp_tk);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 during reset", 32'h0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", 32'h4, 1'b0);
  endtask

  task automatic t_sequential;
    step(32'h0123_4567, 32'h1, 32'h1, 1'b0, "R3 seq 1", 32'h8, 1'b0);
    step(br(6'd3, 16'hFFFF), 32'h5, 32'h5, 1'b0, "R3 seq opcode 3", 32'hC, 1'b0);
  endtask

  task automatic t_branches;
    step(br(6'd4, 16'd3), 32'hAA, 32'hAA, 1'b0, "R4 beq taken", 32'h10 + 32'd12, 1'b1);
    step(br(6'd4, 16'd3), 32'hAA, 32'hAB, 1'b0, "R6 beq fall", 32'h20, 1'b0);
    step(br(6'd5, 16'hFFFE), 32'h1, 32'h2, 1'b0, "R5 R7 bne back", 32'h24 - 32'd8, 1'b1);
    step(br(6'd5, 16'hFFFE), 32'h7, 32'h7, 1'b0, "R6 bne fall", 32'h20, 1'b0);
  endtask

  task automatic t_stall;
    step(jmp(26'h123), 32'h0, 32'h0, 1'b1, "R2 stall jump", 32'h20, 1'b0);
    step(br(6'd4, 16'd9), 32'h3, 32'h3, 1'b1, "R2 stall beq", 32'h20, 1'b0);
  endtask

  task automatic t_jumps;
    step(jmp(26'h3FF_FFFF), 32'h1, 32'h2, 1'b0, "R8 jump low region", 32'h0FFF_FFFC, 1'b1);
    step(jmp(26'd5), 32'h0, 32'h0, 1'b0, "R8 jump upper from pc+4", 32'h1000_0014, 1'b1);
    step(br(6'd4, 16'h8000), 32'h9, 32'h9, 1'b0, "R7 min offset", 32'h1000_0018 - 32'h2_0000, 1'b1);
    step(32'h0, 32'h0, 32'h0, 1'b0, "R9 flag clears", 32'h0FFE_001C, 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: pc=%h taken=%b expected pc=done taken=done", pc_q, taken_q);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_sequential();
    t_branches();
    t_stall();
    t_jumps();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule